// File: doc/BRIEF.md
# Single-Cycle RISC Subset Core

This block is a 32-bit processor that finishes one instruction in every clock cycle. It runs a small load/store instruction subset: word load and store, add, subtract, bitwise AND and OR, signed set-on-less-than, branch-if-equal and an absolute jump. Internally it has a program counter, a 32-entry register file, an ALU and a decoder in two levels. The first level turns the opcode into datapath controls and a 2-bit ALU selector. The second level combines that selector with the function field to pick the ALU operation. The next PC is one of three values: PC+4, the branch target or the jump target.

The instruction memory and the data memory are separate word arrays, and both are read combinationally. A test environment or a boot agent fills them through plain write strobes, normally while reset is held. Each strobe is taken on the clock edge in which it is high. There is no back-pressure on these ports, and no valid/ready handshake, because the block always accepts a write. A side read port shows any data-memory word. The register write of the current instruction is shown on the write-back outputs, so each retired result can be observed.

Top module: `sc_core`

## Requirements
- R1: `rst` is synchronous. A clock edge with `rst` high sets the PC to 0. While `rst` is high, no register write is reported on `wb_en_o` and the core makes no data-memory store.
- R2: A load word (opcode 35) reads the data word at byte address rs + sign-extended imm[15:0]. That word goes to register rt, and the offset may be negative.
- R3: A store word (opcode 43) writes register rt into the data word at rs + sign-extended offset. It writes no register. The external data write port takes priority if both write in the same cycle.
- R4: An R-type instruction (opcode 0) writes rs op rt to register rd. The funct field selects the operation: 32 is add, 34 is subtract, 36 is AND, 37 is OR.
- R5: Funct 42 writes 1 to rd when rs < rt as signed two's-complement numbers, and 0 otherwise.
- R6: Register 0 always reads as zero. A write to it is dropped, and `wb_en_o` stays low for it.
- R7: A branch-if-equal (opcode 4) sets the next PC to PC+4 + (sign-extended imm << 2) when rs equals rt, and to PC+4 when they differ. Backward displacements are supported.
- R8: A jump (opcode 2) sets the next PC to {PC[31:28], instr[25:0], 2'b00}.
- R9: An opcode outside {0, 2, 4, 35, 43}, or an R-type funct outside {32, 34, 36, 37, 42}, changes no register and no memory, and only advances the PC by 4.
- R10: Every instruction other than a taken branch or a jump advances the PC by 4. The PC stays word aligned.
- R11: `imem_wr_en`/`dmem_wr_en` write the addressed word on the clock edge. `dmem_peek_data` shows data word `dmem_peek_idx` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| imem_wr_en | input | 1 | Instruction memory write strobe |
| imem_wr_idx | input | $clog2(IMEM_WORDS) | Instruction word index to write |
| imem_wr_data | input | 32 | Instruction word to write |
| dmem_wr_en | input | 1 | External data memory write strobe |
| dmem_wr_idx | input | $clog2(DMEM_WORDS) | Data word index to write |
| dmem_wr_data | input | 32 | Data word to write |
| dmem_peek_idx | input | $clog2(DMEM_WORDS) | Data word index to observe |
| dmem_peek_data | output | 32 | Data word at `dmem_peek_idx` |
| pc_o | output | 32 | Byte address of the current instruction |
| wb_en_o | output | 1 | Current instruction writes a nonzero register |
| wb_idx_o | output | $clog2(NREG) | Destination register of that write |
| wb_data_o | output | 32 | Value written |

## Verification
A single straight-line program runs through loads, all five R-type operations, a store followed by a load from the same word, a write aimed at register 0, an untaken branch, a taken branch, a jump and a branch that loops back on itself. The operands are chosen so that a mistake becomes visible. Set-on-less-than compares a negative with a positive value in both orders, which separates a signed compare from an unsigned one. The AND and OR operands overlap only partly, so swapped operation codes give different results. A load with a negative offset checks the sign extension. A reset in the middle of the run, while the fetched instruction is a load, shows that reset blocks the write. A read through the peek port after the run shows the stored word and leaves the next word unchanged.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN = 32;

  localparam logic [5:0] OPC_RTYPE = 6'd0;
  localparam logic [5:0] OPC_JUMP  = 6'd2;
  localparam logic [5:0] OPC_BEQ   = 6'd4;
  localparam logic [5:0] OPC_LOAD  = 6'd35;
  localparam logic [5:0] OPC_STORE = 6'd43;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef enum logic [3:0] {
    ALU_AND = 4'b0000,
    ALU_OR  = 4'b0001,
    ALU_ADD = 4'b0010,
    ALU_SUB = 4'b0110,
    ALU_SLT = 4'b0111,
    ALU_NOR = 4'b1100
  } alu_fn_e;

  typedef enum logic [1:0] {
    SEL_ADD   = 2'b00,
    SEL_SUB   = 2'b01,
    SEL_FUNCT = 2'b10
  } alu_sel_e;

  typedef struct packed {
    logic     dst_rd;
    logic     src_imm;
    logic     load;
    logic     store;
    logic     wr_reg;
    logic     branch;
    logic     jump;
    alu_sel_e sel;
  } ctrl_t;
endpackage

// File: rtl/sc_main_ctrl.sv
module sc_main_ctrl
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '0;
    ctrl.sel = SEL_ADD;
    case (opcode)
      OPC_RTYPE: begin
        ctrl.dst_rd = 1'b1;
        ctrl.wr_reg = 1'b1;
        ctrl.sel    = SEL_FUNCT;
      end
      OPC_LOAD: begin
        ctrl.src_imm = 1'b1;
        ctrl.load    = 1'b1;
        ctrl.wr_reg  = 1'b1;
      end
      OPC_STORE: begin
        ctrl.src_imm = 1'b1;
        ctrl.store   = 1'b1;
      end
      OPC_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.sel    = SEL_SUB;
      end
      OPC_JUMP: ctrl.jump = 1'b1;
      default: ctrl = '0;
    endcase
  end
endmodule

// File: rtl/sc_alu_ctrl.sv
module sc_alu_ctrl
  import sc_pkg::*;
(
  input  alu_sel_e   sel,
  input  logic [5:0] funct,
  output alu_fn_e    fn,
  output logic       fn_ok
);
  always_comb begin
    fn    = ALU_ADD;
    fn_ok = 1'b1;
    case (sel)
      SEL_ADD: fn = ALU_ADD;
      SEL_SUB: fn = ALU_SUB;
      SEL_FUNCT: begin
        case (funct)
          FN_ADD:  fn = ALU_ADD;
          FN_SUB:  fn = ALU_SUB;
          FN_AND:  fn = ALU_AND;
          FN_OR:   fn = ALU_OR;
          FN_SLT:  fn = ALU_SLT;
          default: begin
            fn    = ALU_ADD;
            fn_ok = 1'b0;
          end
        endcase
      end
      default: fn = ALU_ADD;
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_fn_e      fn,
  output logic [W-1:0] y,
  output logic         zero
);
  always_comb begin
    case (fn)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      ALU_NOR: y = ~(a | b);
      default: y = '0;
    endcase
  end
  assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W    = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b
);
  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && (waddr != '0)) begin
      regs[waddr] <= wdata;
    end
  end

  assign rd_a = (ra_a == '0) ? '0 : regs[ra_a];
  assign rd_b = (ra_b == '0) ? '0 : regs[ra_b];
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  parameter int NREG       = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          imem_wr_en,
  input  logic [$clog2(IMEM_WORDS)-1:0] imem_wr_idx,
  input  logic [31:0]                   imem_wr_data,
  input  logic                          dmem_wr_en,
  input  logic [$clog2(DMEM_WORDS)-1:0] dmem_wr_idx,
  input  logic [31:0]                   dmem_wr_data,
  input  logic [$clog2(DMEM_WORDS)-1:0] dmem_peek_idx,
  output logic [31:0]                   dmem_peek_data,
  output logic [31:0]                   pc_o,
  output logic                          wb_en_o,
  output logic [$clog2(NREG)-1:0]       wb_idx_o,
  output logic [31:0]                   wb_data_o
);
  localparam int IAW = $clog2(IMEM_WORDS);
  localparam int DAW = $clog2(DMEM_WORDS);
  localparam int RAW = $clog2(NREG);

  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];

  logic [XLEN-1:0] pc_q, pc_next, pc_plus4, br_target, jmp_target;
  logic [XLEN-1:0] instr, imm_sx, rs_val, rt_val, alu_b, alu_y, ld_word, wr_val;
  logic [5:0]      opcode, funct;
  logic [RAW-1:0]  rs_idx, rt_idx, rd_idx, dst_idx;
  ctrl_t           ctrl;
  alu_fn_e         alu_fn;
  logic            fn_ok, alu_zero, reg_we;
  logic            unused_shamt;

  // fetch
  assign instr  = imem[pc_q[IAW+1:2]];
  assign opcode = instr[31:26];
  assign rs_idx = instr[21+RAW-1:21];
  assign rt_idx = instr[16+RAW-1:16];
  assign rd_idx = instr[11+RAW-1:11];
  assign funct  = instr[5:0];
  assign imm_sx = {{(XLEN-16){instr[15]}}, instr[15:0]};
  assign unused_shamt = ^instr[10:6];

  // two-level decode
  sc_main_ctrl u_main (
    .opcode (opcode),
    .ctrl   (ctrl)
  );

  sc_alu_ctrl u_aluc (
    .sel   (ctrl.sel),
    .funct (funct),
    .fn    (alu_fn),
    .fn_ok (fn_ok)
  );

  // operands and execute
  sc_regfile #(.W(XLEN), .NREG(NREG)) u_rf (
    .clk   (clk),
    .rst   (rst),
    .we    (reg_we),
    .waddr (dst_idx),
    .wdata (wr_val),
    .ra_a  (rs_idx),
    .ra_b  (rt_idx),
    .rd_a  (rs_val),
    .rd_b  (rt_val)
  );

  assign alu_b = ctrl.src_imm ? imm_sx : rt_val;

  sc_alu #(.W(XLEN)) u_alu (
    .a    (rs_val),
    .b    (alu_b),
    .fn   (alu_fn),
    .y    (alu_y),
    .zero (alu_zero)
  );

  // memory and write-back
  assign ld_word = dmem[alu_y[DAW+1:2]];
  assign wr_val  = ctrl.load ? ld_word : alu_y;
  assign dst_idx = ctrl.dst_rd ? rd_idx : rt_idx;
  assign reg_we  = ctrl.wr_reg && fn_ok && !rst;

  always_ff @(posedge clk) begin
    if (imem_wr_en) imem[imem_wr_idx] <= imem_wr_data;
  end

  always_ff @(posedge clk) begin
    if (dmem_wr_en)
      dmem[dmem_wr_idx] <= dmem_wr_data;
    else if (ctrl.store && !rst)
      dmem[alu_y[DAW+1:2]] <= rt_val;
  end

  assign dmem_peek_data = dmem[dmem_peek_idx];

  // next PC
  assign pc_plus4   = pc_q + 32'd4;
  assign br_target  = pc_plus4 + {imm_sx[XLEN-3:0], 2'b00};
  assign jmp_target = {pc_q[31:28], instr[25:0], 2'b00};

  always_comb begin
    if (ctrl.jump)
      pc_next = jmp_target;
    else if (ctrl.branch && alu_zero)
      pc_next = br_target;
    else
      pc_next = pc_plus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  assign pc_o      = pc_q;
  assign wb_en_o   = reg_we && (dst_idx != '0);
  assign wb_idx_o  = dst_idx;
  assign wb_data_o = wr_val;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk #(
  parameter int IDXW = 5
) (
  input logic            clk,
  input logic            rst,
  input logic [31:0]     pc,
  input logic [31:0]     instr,
  input logic            wb_en,
  input logic [IDXW-1:0] wb_idx
);
  logic       rst_d = 1'b0;
  logic [5:0] op;
  logic       op_known;

  assign op       = instr[31:26];
  assign op_known = (op == 6'd0) || (op == 6'd2) || (op == 6'd4) ||
                    (op == 6'd35) || (op == 6'd43);

  always_ff @(posedge clk) rst_d <= rst;

  // R1: an edge taken in reset leaves the PC at zero
  always_ff @(posedge clk) begin
    if (rst_d) p_pc_zero_r1: assert (pc == 32'd0) else $error("pc not cleared by reset");
  end

  // R1: no reported write while reset is held
  always_ff @(posedge clk) begin
    if (rst) p_quiet_reset_r1: assert (!wb_en) else $error("write during reset");
  end

  p_r0_never_r6: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> (wb_idx != '0));

  p_pc_aligned_r10: assert property (@(posedge clk) disable iff (rst)
    pc[1:0] == 2'b00);

  p_seq_pc_r10: assert property (@(posedge clk) disable iff (rst)
    (op != 6'd4 && op != 6'd2) |=> (pc == $past(pc) + 32'd4));

  p_jump_r8: assert property (@(posedge clk) disable iff (rst)
    (op == 6'd2) |=> (pc == {$past(pc[31:28]), $past(instr[25:0]), 2'b00}));

  p_store_nowb_r3: assert property (@(posedge clk) disable iff (rst)
    (op == 6'd43) |-> !wb_en);

  p_unknown_op_r9: assert property (@(posedge clk) disable iff (rst)
    !op_known |-> !wb_en);
endmodule

bind sc_core sc_core_chk #(.IDXW($clog2(NREG))) u_chk (
  .clk    (clk),
  .rst    (rst),
  .pc     (pc_o),
  .instr  (instr),
  .wb_en  (wb_en_o),
  .wb_idx (wb_idx_o)
);

// File: tb/sc_core_tb.sv
module sc_core_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 20;

  // {pc, wb_en, wb_idx, wb_data}
  localparam logic [69:0] VEC [NVEC] = '{
    {32'h00, 1'b1, 5'd1,  32'd5},
    {32'h04, 1'b1, 5'd2,  32'd7},
    {32'h08, 1'b1, 5'd3,  32'd12},
    {32'h0C, 1'b1, 5'd4,  32'hFFFF_FFFE},
    {32'h10, 1'b1, 5'd5,  32'd4},
    {32'h14, 1'b1, 5'd6,  32'd15},
    {32'h18, 1'b1, 5'd7,  32'd1},
    {32'h1C, 1'b1, 5'd8,  32'd0},
    {32'h20, 1'b0, 5'd0,  32'd0},
    {32'h24, 1'b1, 5'd9,  32'd12},
    {32'h28, 1'b0, 5'd0,  32'd0},
    {32'h2C, 1'b1, 5'd10, 32'd5},
    {32'h30, 1'b0, 5'd0,  32'd0},
    {32'h34, 1'b0, 5'd0,  32'd0},
    {32'h40, 1'b1, 5'd12, 32'hFFFF_FFF0},
    {32'h44, 1'b0, 5'd0,  32'd0},
    {32'h48, 1'b0, 5'd0,  32'd0},
    {32'h4C, 1'b0, 5'd0,  32'd0},
    {32'h54, 1'b0, 5'd0,  32'd0},
    {32'h54, 1'b0, 5'd0,  32'd0}
  };
  localparam string VREQ [NVEC] = '{
    "R2", "R2", "R4", "R4", "R10", "R4", "R5", "R5", "R3", "R3",
    "R6", "R6", "R7", "R7", "R7", "R9", "R9", "R8", "R8", "R7"
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        imem_wr_en = 1'b0;
  logic [5:0]  imem_wr_idx = '0;
  logic [31:0] imem_wr_data = '0;
  logic        dmem_wr_en = 1'b0;
  logic [5:0]  dmem_wr_idx = '0;
  logic [31:0] dmem_wr_data = '0;
  logic [5:0]  dmem_peek_idx = '0;
  logic [31:0] dmem_peek_data, pc_o, wb_data_o;
  logic        wb_en_o;
  logic [4:0]  wb_idx_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sc_core u_dut (
    .clk            (clk),
    .rst            (rst),
    .imem_wr_en     (imem_wr_en),
    .imem_wr_idx    (imem_wr_idx),
    .imem_wr_data   (imem_wr_data),
    .dmem_wr_en     (dmem_wr_en),
    .dmem_wr_idx    (dmem_wr_idx),
    .dmem_wr_data   (dmem_wr_data),
    .dmem_peek_idx  (dmem_peek_idx),
    .dmem_peek_data (dmem_peek_data),
    .pc_o           (pc_o),
    .wb_en_o        (wb_en_o),
    .wb_idx_o       (wb_idx_o),
    .wb_data_o      (wb_data_o)
  );

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, int fn);
    return {6'd0, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn[5:0]};
  endfunction

  function automatic logic [31:0] enc_i(int op, int rs, int rt, logic [15:0] imm);
    return {op[5:0], rs[4:0], rt[4:0], imm};
  endfunction

  function automatic logic [31:0] enc_j(int op, logic [25:0] tgt);
    return {op[5:0], tgt};
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic put_imem(int idx, logic [31:0] w);
    imem_wr_en = 1'b1; imem_wr_idx = idx[5:0]; imem_wr_data = w;
    @(negedge clk);
    imem_wr_en = 1'b0;
  endtask

  task automatic put_dmem(int idx, logic [31:0] w);
    dmem_wr_en = 1'b1; dmem_wr_idx = idx[5:0]; dmem_wr_data = w;
    @(negedge clk);
    dmem_wr_en = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    #1;
    check("R1", "pc in reset", pc_o, 32'h0);
    check("R1", "wb_en in reset", {31'd0, wb_en_o}, 32'd0);

    // R11: fill both memories through the write ports
    put_dmem(0, 32'd5);
    put_dmem(1, 32'd7);
    put_dmem(2, 32'hFFFF_FFF0);
    put_dmem(3, 32'd0);
    put_imem(0,  enc_i(35, 0, 1, 16'd0));
    put_imem(1,  enc_i(35, 0, 2, 16'd4));
    put_imem(2,  enc_r(1, 2, 3, 32));
    put_imem(3,  enc_r(1, 2, 4, 34));
    put_imem(4,  enc_r(3, 2, 5, 36));
    put_imem(5,  enc_r(3, 2, 6, 37));
    put_imem(6,  enc_r(4, 1, 7, 42));
    put_imem(7,  enc_r(1, 4, 8, 42));
    put_imem(8,  enc_i(43, 0, 3, 16'd12));
    put_imem(9,  enc_i(35, 0, 9, 16'd12));
    put_imem(10, enc_r(1, 2, 0, 32));
    put_imem(11, enc_r(0, 1, 10, 32));
    put_imem(12, enc_i(4, 1, 2, 16'd5));
    put_imem(13, enc_i(4, 1, 10, 16'd2));
    put_imem(14, enc_r(1, 1, 11, 32));
    put_imem(15, enc_r(2, 2, 11, 32));
    put_imem(16, enc_i(35, 3, 12, 16'hFFFC));
    put_imem(17, enc_i(63, 1, 13, 16'd8));
    put_imem(18, enc_r(1, 2, 13, 63));
    put_imem(19, enc_j(2, 26'h15));
    put_imem(20, enc_r(1, 1, 14, 32));
    put_imem(21, enc_i(4, 0, 0, 16'hFFFF));

    dmem_peek_idx = 6'd0;
    #1;
    check("R11", "peek word 0", dmem_peek_data, 32'd5);

    rst = 1'b0;
    for (int v = 0; v < NVEC; v++) begin
      #1;
      check(VREQ[v], "pc", pc_o, VEC[v][69:38]);
      check(VREQ[v], "wb_en", {31'd0, wb_en_o}, {31'd0, VEC[v][37]});
      if (VEC[v][37]) begin
        check(VREQ[v], "wb_idx", {27'd0, wb_idx_o}, {27'd0, VEC[v][36:32]});
        check(VREQ[v], "wb_data", wb_data_o, VEC[v][31:0]);
      end
      @(negedge clk);
    end

    // R3: the store hit word 3 only
    dmem_peek_idx = 6'd3;
    #1;
    check("R3", "stored word 3", dmem_peek_data, 32'd12);
    dmem_peek_idx = 6'd2;
    #1;
    check("R3", "neighbour word 2", dmem_peek_data, 32'hFFFF_FFF0);

    // R1: reset in mid-run, then a load fetched while reset is held
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    #1;
    check("R1", "pc after mid-run reset", pc_o, 32'h0);
    check("R1", "load blocked in reset", {31'd0, wb_en_o}, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1", "restart pc", pc_o, 32'h0);
    check("R2", "restart load data", wb_data_o, 32'd5);
    @(negedge clk);
    #1;
    check("R10", "pc step after restart", pc_o, 32'h4);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (3000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule